// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialisation Sequencer

This block takes charge of an asynchronous DRAM array in two situations: bringing it up after reset and keeping its contents alive afterwards. Out of reset it holds every strobe inactive for a programmable pause. It then runs a fixed burst of refresh cycles that wakes up the array, and only after that does it raise `initDone`. From then on an interval timer adds one refresh to a backlog every `INTERVAL_CYC` clocks. The sequencer works the backlog off between host accesses.

The access controller asks for the memory bus with `hostReq` and owns it while `hostGnt` is high. A refresh never cuts into a granted access. Missed intervals pile up in a small backlog counter and are served back to back once the host lets go. If the backlog ever exceeds `PEND_LIMIT`, a sticky error flag is raised.

Two refresh styles are available through `modeRasOnly`:
- **CAS-before-RAS.** All CAS lines fall ahead of RAS and stay low through the RAS-low phase.
- **RAS-only.** CAS stays high and the sequencer's own row counter is presented on `addr`. The counter advances after every RAS-only cycle and wraps to zero.

All RAS lines switch together, and so do all CAS lines. `weN` is never asserted.

Top module: `refseq_top`

## Requirements
- R1: While `rstN` is low, `rasN` and `casN` are all ones, `weN` is 1, `addr` is 0, and `initDone`, `hostGnt` and `refErr` are 0.
- R2: No RAS line falls until at least `PAUSE_CYC` clocks after reset is released.
- R3: After the pause, exactly `INIT_CNT` refresh cycles of the style selected by `modeRasOnly` run before `initDone` rises. `initDone` stays high once set.
- R4: In a CAS-before-RAS cycle (`modeRasOnly`=0), all CAS lines are low for at least one clock before RAS falls. They stay low for the whole RAS-low phase.
- R5: `weN` is 1 at every RAS fall and at all other times.
- R6: RAS stays low for exactly `ACT_CYC` clocks per refresh cycle. RAS stays high for at least `PRE_CYC` clocks between cycles.
- R7: In a RAS-only cycle (`modeRasOnly`=1):
  - CAS stays all ones, and `addr` carries the row counter and is stable while RAS is low.
  - The row counter starts at 0 and goes up by one after each RAS-only cycle, wrapping from 1023 to 0.
  - CAS-before-RAS cycles leave the row counter unchanged.
- R8: The four RAS lines always carry the same value, and so do the four CAS lines.
- R9: `hostGnt` stays 0 until `initDone` is 1. With no backlog, a pending `hostReq` is granted within 3 clocks of `initDone` rising.
- R10: With the bus idle, successive refresh cycles begin exactly `INTERVAL_CYC` clocks apart.
- R11: No RAS line falls while `hostGnt` is 1. Intervals that elapse during a grant are each served by one refresh cycle after `hostReq` drops.
- R12: `refErr` rises once the backlog exceeds `PEND_LIMIT` (8) and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeRasOnly | input | 1 | 0 = CAS-before-RAS refresh, 1 = RAS-only refresh with internal row counter |
| hostReq | input | 1 | Access controller requests the memory bus |
| hostGnt | output | 1 | Access controller owns the bus |
| initDone | output | 1 | Power-up pause and initialisation burst complete |
| refErr | output | 1 | Sticky: refresh backlog exceeded its limit |
| rasN | output | NUM_RAS | Row strobes, active low |
| casN | output | NUM_CAS | Column strobes, active low |
| weN | output | 1 | Write enable, active low, held inactive |
| addr | output | ROW_W | Row address for RAS-only refresh |

## Verification
The bench holds `hostReq` high from reset. A sequencer that granted before initialisation ended would then hand the bus out during the pause. It counts the cycles of the initialisation burst, which exposes a burst that is too short or long. It also steps the RAS-only row counter through more than 1024 cycles, so a counter that failed to wrap, skipped a row, or moved during CAS-before-RAS cycles would present the wrong row at some RAS fall. Holding the grant over several intervals shows whether missed refreshes are replayed afterwards or silently dropped. Holding it over more than eight intervals shows whether the error flag rises and then stays up.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

  // Sequencer states
  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_LEAD,
    ST_ACT,
    ST_PRE,
    ST_IDLE,
    ST_HOST
  } seqState_t;

  // Which phase length the datapath loads into its phase timer
  typedef enum logic [1:0] {
    PH_LEAD,
    PH_ACT,
    PH_PRE
  } phaseSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic      loadPhase;  // reload the phase timer
    phaseSel_t phase;      // which length to load
    logic      latchMode;  // capture refresh style for the coming cycle
    logic      rasOn;      // RAS low in the next clock
    logic      casCbr;     // CAS low in the next clock if style is CAS-before-RAS
    logic      initDec;    // one init cycle consumed
    logic      pendDec;    // one backlog entry served
    logic      rowAdv;     // advance row counter (RAS-only cycles only)
    logic      setInit;    // initialisation finished
  } seqStrobe_t;

endpackage

// File: rtl/refseq_datapath.sv
module refseq_datapath
  import refseq_pkg::*;
#(
  parameter int NUM_RAS      = 4,
  parameter int NUM_CAS      = 4,
  parameter int ROW_W        = 10,
  parameter int PAUSE_CYC    = 20000,
  parameter int INIT_CNT     = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int LEAD_CYC     = 1,
  parameter int ACT_CYC      = 6,
  parameter int PRE_CYC      = 5,
  parameter int PEND_LIMIT   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeRasOnly,
  input  seqStrobe_t         strobe,
  output logic               pauseDone,
  output logic               phaseDone,
  output logic               initLast,
  output logic               pendAny,
  output logic               initDone,
  output logic               refErr,
  output logic [NUM_RAS-1:0] rasN,
  output logic [NUM_CAS-1:0] casN,
  output logic               weN,
  output logic [ROW_W-1:0]   addr
);

  localparam int PAUSE_W = $clog2(PAUSE_CYC + 1);
  localparam int PH_MAX1 = (LEAD_CYC > ACT_CYC) ? LEAD_CYC : ACT_CYC;
  localparam int PH_MAX  = (PH_MAX1 > PRE_CYC) ? PH_MAX1 : PRE_CYC;
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int INIT_W  = $clog2(INIT_CNT + 1);
  localparam int IVL_W   = $clog2(INTERVAL_CYC + 1);
  localparam int PEND_W  = $clog2(PEND_LIMIT + 2) + 1;

  // ---------------- power-up pause ----------------
  logic [PAUSE_W-1:0] pauseCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pauseCnt  <= '0;
      pauseDone <= 1'b0;
    end else if (!pauseDone) begin
      if (pauseCnt == PAUSE_W'(PAUSE_CYC - 1)) pauseDone <= 1'b1;
      else                                     pauseCnt  <= pauseCnt + 1'b1;
    end
  end

  // ---------------- phase timer ----------------
  logic [PH_W-1:0] phaseCnt;
  logic [PH_W-1:0] phaseLoad;

  always_comb begin
    unique case (strobe.phase)
      PH_LEAD: phaseLoad = PH_W'(LEAD_CYC - 1);
      PH_ACT:  phaseLoad = PH_W'(ACT_CYC - 1);
      default: phaseLoad = PH_W'(PRE_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseCnt <= '0;
    else if (strobe.loadPhase) phaseCnt <= phaseLoad;
    else if (phaseCnt != '0)   phaseCnt <= phaseCnt - 1'b1;
  end

  assign phaseDone = (phaseCnt == '0);

  // ---------------- initialisation burst ----------------
  logic [INIT_W-1:0] initRemain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initRemain <= INIT_W'(INIT_CNT);
      initDone   <= 1'b0;
    end else begin
      if (strobe.initDec && initRemain != '0) initRemain <= initRemain - 1'b1;
      if (strobe.setInit)                     initDone   <= 1'b1;
    end
  end

  assign initLast = (initRemain == '0);

  // ---------------- interval timer ----------------
  logic [IVL_W-1:0] ivlCnt;
  logic             tick;

  assign tick = initDone && (ivlCnt == IVL_W'(INTERVAL_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          ivlCnt <= '0;
    else if (!initDone) ivlCnt <= '0;
    else if (tick)      ivlCnt <= '0;
    else                ivlCnt <= ivlCnt + 1'b1;
  end

  // ---------------- refresh backlog ----------------
  logic [PEND_W-1:0] pendCnt;
  logic [PEND_W-1:0] pendNext;

  always_comb begin
    pendNext = pendCnt;
    unique case ({tick, strobe.pendDec})
      2'b10:   if (pendCnt != '1) pendNext = pendCnt + 1'b1;
      2'b01:   if (pendCnt != '0) pendNext = pendCnt - 1'b1;
      default: pendNext = pendCnt;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendCnt <= '0;
      refErr  <= 1'b0;
    end else begin
      pendCnt <= pendNext;
      if (pendCnt > PEND_W'(PEND_LIMIT)) refErr <= 1'b1;
    end
  end

  assign pendAny = (pendCnt != '0);

  // ---------------- refresh style and row counter ----------------
  logic             modeLat;
  logic [ROW_W-1:0] rowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeLat <= 1'b0;
      rowCnt  <= '0;
    end else begin
      if (strobe.latchMode)          modeLat <= modeRasOnly;
      if (strobe.rowAdv && modeLat)  rowCnt  <= rowCnt + 1'b1;
    end
  end

  assign addr = rowCnt;
  assign weN  = 1'b1;

  // ---------------- strobe output registers, one per line ----------------
  logic rasDrive;
  logic casDrive;

  assign rasDrive = strobe.rasOn;
  assign casDrive = strobe.casCbr & ~modeLat;

  for (genvar g = 0; g < NUM_RAS; g++) begin : gRasLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) rasN[g] <= 1'b1;
      else       rasN[g] <= ~rasDrive;
    end
  end

  for (genvar g = 0; g < NUM_CAS; g++) begin : gCasLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) casN[g] <= 1'b1;
      else       casN[g] <= ~casDrive;
    end
  end

endmodule

// File: rtl/refseq_control.sv
module refseq_control
  import refseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostReq,
  input  logic       pauseDone,
  input  logic       phaseDone,
  input  logic       initLast,
  input  logic       initDone,
  input  logic       pendAny,
  output seqStrobe_t strobe,
  output logic       hostGnt
);

  seqState_t state;
  seqState_t stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_PAUSE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;

    unique case (state)
      ST_PAUSE: begin
        if (pauseDone) begin
          stateNext        = ST_LEAD;
          strobe.loadPhase = 1'b1;
          strobe.phase     = PH_LEAD;
          strobe.latchMode = 1'b1;
        end
      end

      ST_LEAD: begin
        strobe.casCbr = 1'b1;
        if (phaseDone) begin
          stateNext        = ST_ACT;
          strobe.loadPhase = 1'b1;
          strobe.phase     = PH_ACT;
        end
      end

      ST_ACT: begin
        strobe.rasOn  = 1'b1;
        strobe.casCbr = 1'b1;
        if (phaseDone) begin
          stateNext        = ST_PRE;
          strobe.loadPhase = 1'b1;
          strobe.phase     = PH_PRE;
          strobe.initDec   = ~initDone;
        end
      end

      ST_PRE: begin
        if (phaseDone) begin
          strobe.rowAdv  = 1'b1;
          strobe.pendDec = initDone;
          if (initDone) begin
            stateNext = ST_IDLE;
          end else if (initLast) begin
            strobe.setInit = 1'b1;
            stateNext      = ST_IDLE;
          end else begin
            stateNext        = ST_LEAD;
            strobe.loadPhase = 1'b1;
            strobe.phase     = PH_LEAD;
            strobe.latchMode = 1'b1;
          end
        end
      end

      ST_IDLE: begin
        if (pendAny) begin
          stateNext        = ST_LEAD;
          strobe.loadPhase = 1'b1;
          strobe.phase     = PH_LEAD;
          strobe.latchMode = 1'b1;
        end else if (hostReq) begin
          stateNext = ST_HOST;
        end
      end

      ST_HOST: begin
        if (!hostReq) stateNext = ST_IDLE;
      end

      default: stateNext = ST_PAUSE;
    endcase
  end

  assign hostGnt = (state == ST_HOST);

endmodule

// File: rtl/refseq_top.sv
module refseq_top
  import refseq_pkg::*;
#(
  parameter int NUM_RAS      = 4,
  parameter int NUM_CAS      = 4,
  parameter int ROW_W        = 10,
  parameter int PAUSE_CYC    = 20000,
  parameter int INIT_CNT     = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int LEAD_CYC     = 1,
  parameter int ACT_CYC      = 6,
  parameter int PRE_CYC      = 5,
  parameter int PEND_LIMIT   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeRasOnly,
  input  logic               hostReq,
  output logic               hostGnt,
  output logic               initDone,
  output logic               refErr,
  output logic [NUM_RAS-1:0] rasN,
  output logic [NUM_CAS-1:0] casN,
  output logic               weN,
  output logic [ROW_W-1:0]   addr
);

  seqStrobe_t strobe;
  logic       pauseDone;
  logic       phaseDone;
  logic       initLast;
  logic       pendAny;

  refseq_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .hostReq   (hostReq),
    .pauseDone (pauseDone),
    .phaseDone (phaseDone),
    .initLast  (initLast),
    .initDone  (initDone),
    .pendAny   (pendAny),
    .strobe    (strobe),
    .hostGnt   (hostGnt)
  );

  refseq_datapath #(
    .NUM_RAS      (NUM_RAS),
    .NUM_CAS      (NUM_CAS),
    .ROW_W        (ROW_W),
    .PAUSE_CYC    (PAUSE_CYC),
    .INIT_CNT     (INIT_CNT),
    .INTERVAL_CYC (INTERVAL_CYC),
    .LEAD_CYC     (LEAD_CYC),
    .ACT_CYC      (ACT_CYC),
    .PRE_CYC      (PRE_CYC),
    .PEND_LIMIT   (PEND_LIMIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .modeRasOnly (modeRasOnly),
    .strobe      (strobe),
    .pauseDone   (pauseDone),
    .phaseDone   (phaseDone),
    .initLast    (initLast),
    .pendAny     (pendAny),
    .initDone    (initDone),
    .refErr      (refErr),
    .rasN        (rasN),
    .casN        (casN),
    .weN         (weN),
    .addr        (addr)
  );

endmodule

// File: rtl/refseq_checker.sv
module refseq_checker #(
  parameter int NUM_RAS = 4,
  parameter int NUM_CAS = 4,
  parameter int ROW_W   = 10
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostGnt,
  input logic               initDone,
  input logic               refErr,
  input logic [NUM_RAS-1:0] rasN,
  input logic [NUM_CAS-1:0] casN,
  input logic [ROW_W-1:0]   addr
);

  logic rasLow;
  logic casLow;
  logic casHigh;

  assign rasLow  = (rasN == '0);
  assign casLow  = (casN == '0);
  assign casHigh = (casN == '1);

  assert_no_ras_while_granted_R11: assert property (@(posedge clk) disable iff (!rstN)
    hostGnt |-> (rasN == '1));

  assert_grant_needs_init_R9: assert property (@(posedge clk) disable iff (!rstN)
    !initDone |-> !hostGnt);

  assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rasLow) && casLow) |-> $past(casLow));

  assert_row_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rasLow && $past(rasLow)) |-> $stable(addr));

  assert_rasonly_cas_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rasLow) && !casLow) |-> casHigh);

  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rstN)
    refErr |=> refErr);

  assert_init_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

endmodule

bind refseq_top refseq_checker #(
  .NUM_RAS (NUM_RAS),
  .NUM_CAS (NUM_CAS),
  .ROW_W   (ROW_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .hostGnt  (hostGnt),
  .initDone (initDone),
  .refErr   (refErr),
  .rasN     (rasN),
  .casN     (casN),
  .addr     (addr)
);

// File: tb/sim_refseq_top.sv
module sim_refseq_top;

  localparam int CLK_PERIOD   = 10;
  localparam int PAUSE_CYC    = 40;
  localparam int INIT_CNT     = 8;
  localparam int INTERVAL_CYC = 20;
  localparam int ACT_CYC      = 6;
  localparam int PRE_CYC      = 5;
  localparam int RO_RUN       = 1030;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeRasOnly = 1'b0;
  logic       hostReq = 1'b1;
  logic       hostGnt;
  logic       initDone;
  logic       refErr;
  logic [3:0] rasN;
  logic [3:0] casN;
  logic       weN;
  logic [9:0] addr;

  int checks = 0;
  int errors = 0;

  refseq_top #(
    .PAUSE_CYC    (PAUSE_CYC),
    .INIT_CNT     (INIT_CNT),
    .INTERVAL_CYC (INTERVAL_CYC),
    .ACT_CYC      (ACT_CYC),
    .PRE_CYC      (PRE_CYC)
  ) u0 (
    .clk         (clk),
    .rstN        (rstN),
    .modeRasOnly (modeRasOnly),
    .hostReq     (hostReq),
    .hostGnt     (hostGnt),
    .initDone    (initDone),
    .refErr      (refErr),
    .rasN        (rasN),
    .casN        (casN),
    .weN         (weN),
    .addr        (addr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Scoreboard queue: expected row at each RAS-only RAS fall
  int unsigned rowQ[$];
  int unsigned expRow = 0;

  // Monitor state
  int   sinceRel = 0;
  int   lowLen = 0;
  int   highLen = 1000;
  int   initFalls = 0;
  int   initCbr = 0;
  int   fallTotal = 0;
  int   fallStamp = 0;
  bit   curCbr = 1'b0;
  bit   prevInit = 1'b0;
  logic [3:0] prevRas = 4'hF;
  logic [3:0] prevCas = 4'hF;
  logic [9:0] prevAddr = '0;
  event rasFellEv;

  always @(negedge clk) begin
    if (rstN) begin
      sinceRel++;
      if (rasN != prevRas) check(rasN == 4'h0 || rasN == 4'hF, "R8 ras lanes", rasN, 0);
      if (casN != prevCas) check(casN == 4'h0 || casN == 4'hF, "R8 cas lanes", casN, 0);
      if (!initDone) check(!hostGnt, "R9 grant before init", hostGnt, 0);

      if (prevRas == 4'hF && rasN == 4'h0) begin
        check(sinceRel >= PAUSE_CYC, "R2 pause", sinceRel, PAUSE_CYC);
        check(weN == 1'b1, "R5 we inactive", weN, 1);
        check(!hostGnt, "R11 ras during grant", hostGnt, 0);
        check(highLen >= PRE_CYC, "R6 ras high time", highLen, PRE_CYC);
        curCbr = (casN == 4'h0);
        if (curCbr) begin
          check(prevCas == 4'h0, "R4 cas lead", prevCas, 0);
        end else begin
          check(casN == 4'hF, "R7 cas high", casN, 15);
          if (rowQ.size() != 0) begin
            int unsigned e;
            e = rowQ.pop_front();
            check(addr == 10'(e), "R7 row address", addr, e);
          end else begin
            check(1'b0, "R7 unexpected ras-only cycle", addr, -1);
          end
        end
        if (!initDone) begin
          initFalls++;
          if (curCbr) initCbr++;
        end
        fallTotal++;
        lowLen = 1;
        fallStamp = sinceRel;
        ->rasFellEv;
      end else if (prevRas == 4'h0 && rasN == 4'h0) begin
        lowLen++;
        if (curCbr) check(casN == 4'h0, "R4 cas hold", casN, 0);
        else        check(casN == 4'hF && addr == prevAddr, "R7 row hold", addr, prevAddr);
      end else if (prevRas == 4'h0 && rasN == 4'hF) begin
        check(lowLen == ACT_CYC, "R6 ras low width", lowLen, ACT_CYC);
        highLen = 1;
      end else begin
        highLen++;
      end

      if (initDone && !prevInit) begin
        check(initFalls == INIT_CNT, "R3 init cycle count", initFalls, INIT_CNT);
        check(initCbr == INIT_CNT, "R3 init cycle style", initCbr, INIT_CNT);
      end

      prevRas  = rasN;
      prevCas  = casN;
      prevAddr = addr;
      prevInit = initDone;
    end
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    finishRun();
  end

  // Driver
  initial begin
    int base;
    int t0;
    int t1;
    int t2;
    repeat (3) @(negedge clk);
    check(rasN == 4'hF, "R1 reset rasN", rasN, 15);
    check(casN == 4'hF, "R1 reset casN", casN, 15);
    check(weN == 1'b1, "R1 reset weN", weN, 1);
    check(addr == 10'd0, "R1 reset addr", addr, 0);
    check(!initDone && !hostGnt && !refErr, "R1 reset flags",
          {initDone, hostGnt, refErr}, 0);
    rstN = 1'b1;

    // hostReq is high throughout initialisation
    while (!initDone) @(negedge clk);
    begin
      int waited = 0;
      while (!hostGnt && waited < 4) begin
        @(negedge clk);
        waited++;
      end
      check(hostGnt && waited <= 3, "R9 grant after init", waited, 3);
    end

    // Hold the grant over several intervals, then release
    repeat (5 * INTERVAL_CYC) @(negedge clk);
    hostReq = 1'b0;
    base = fallTotal;
    repeat (70) @(negedge clk);
    check(fallTotal - base >= 5, "R11 backlog replay", fallTotal - base, 5);
    check(refErr == 1'b0, "R12 no error on small backlog", refErr, 0);

    // Interval spacing on an idle bus
    repeat (100) @(negedge clk);
    @(rasFellEv);
    t0 = fallStamp;
    @(rasFellEv);
    t1 = fallStamp;
    @(rasFellEv);
    t2 = fallStamp;
    check(t1 - t0 == INTERVAL_CYC, "R10 spacing a", t1 - t0, INTERVAL_CYC);
    check(t2 - t1 == INTERVAL_CYC, "R10 spacing b", t2 - t1, INTERVAL_CYC);

    // RAS-only run across the row wrap
    @(rasFellEv);
    for (int i = 0; i < RO_RUN; i++) begin
      rowQ.push_back(expRow);
      expRow = (expRow + 1) % 1024;
    end
    modeRasOnly = 1'b1;
    while (rowQ.size() != 0) @(negedge clk);
    modeRasOnly = 1'b0;
    repeat (3 * INTERVAL_CYC) @(negedge clk);
    check(addr == 10'(expRow), "R7 row kept over cas-before-ras", addr, expRow);

    // Long grant: backlog overflows
    hostReq = 1'b1;
    while (!hostGnt) @(negedge clk);
    repeat (10 * INTERVAL_CYC + 20) @(negedge clk);
    check(refErr == 1'b1, "R12 error raised", refErr, 1);
    hostReq = 1'b0;
    repeat (200) @(negedge clk);
    check(refErr == 1'b1, "R12 error sticky", refErr, 1);
    check(weN == 1'b1, "R5 we idle", weN, 1);

    finishRun();
  end

endmodule